// File: doc/BRIEF.md
# ATM Cell Next-Hop Relabeller

This block sits on a 32-bit ATM cell stream between a line input and a cell output. One virtual circuit, whose number is held in a runtime register input, carries IP packets. For the first cell of each IP packet on that circuit, the block takes the IPv4 destination address from the payload and offers it to an external lookup engine through an address queue interface. It holds the packet's cells in an internal cell FIFO. It then takes the next-hop value from the lookup engine's result interface and writes that value into the VCI field of every cell of the packet on the way out. Cells on any other circuit leave unchanged and in arrival order.

A cell is 14 words: the header word, a HEC/pad word and twelve payload words. The header word carries GFC/VPI in bits [31:20], the VCI in bits [19:4], the PTI in bits [3:1] and CLP in bit 0. Bit 1 (the lowest PTI bit) marks the last cell of an AAL5 frame, and so the end of an IP packet. The destination address is the 7th word of the first cell (word index 6 when the header is index 0).

The input parser has two states. PS_HEADER waits for a word with the start strobe and moves to PS_PAYLOAD. PS_PAYLOAD returns to PS_HEADER after the 14th word. The output scheduler has three states. OS_IDLE moves to OS_SEND when a whole cell is stored and the transmit-available input is high, and the cell either needs no new result or finds one waiting. OS_IDLE moves to OS_WAIT_NH when the cell needs a result that has not arrived. OS_WAIT_NH moves to OS_SEND once a result is present and transmit-available is high. OS_SEND returns to OS_IDLE after the 14th word.

Top module: `atm_ip_relabel`

## Requirements
- R1: While reset is held, out_valid, addr_valid and res_pop are low and in_ready is high.
- R2: Output cells are sent as 14 words in consecutive cycles, with out_soc high on the first word only and in their order of arrival. An input word that arrives while no cell is open and lacks in_soc is dropped.
- R3: A cell is IP traffic when header bits [19:4] equal cfg_ip_vci at the moment its header word is accepted.
- R4: All 14 words of a non-IP cell leave bit-for-bit unchanged.
- R5: For the first cell of each IP packet, word index 6 is offered on addr_data, with addr_valid high, in the cycle it is accepted. It is offered once per packet. While addr_ready is low, in_ready holds that word back.
- R6: The header word of an IP cell leaves with bits [19:4] replaced by the packet's next hop. Bits [31:20] and [3:0] are kept. The other 13 words are unchanged.
- R7: Every cell of a multi-cell IP packet carries the same next hop. The packet ends with the IP cell whose header bit 1 is set, and non-IP cells may be interleaved.
- R8: Exactly one result is popped per IP packet, only while res_valid is high, and never in two adjacent cycles. Results are bound to packets in address order, and an IP cell waits for its result.
- R9: The first word of an output cell appears only if out_tca was high in the previous cycle.
- R10: When the cell FIFO holds CELL_DEPTH×14 words, in_ready is low, and no accepted word is lost.
- R11: Changing cfg_ip_vci between packets reclassifies the cells that arrive afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ip_vci | input | 16 | VCI of the circuit carrying IP packets |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word accepted this cycle if in_valid |
| in_soc | input | 1 | Input word is the header of a cell |
| in_data | input | 32 | Input cell word |
| out_tca | input | 1 | Downstream can take a cell |
| out_valid | output | 1 | Output word present |
| out_soc | output | 1 | Output word is a cell header |
| out_data | output | 32 | Output cell word |
| addr_valid | output | 1 | Destination address offered |
| addr_ready | input | 1 | Address queue has room |
| addr_data | output | 32 | Destination address |
| res_valid | input | 1 | Next-hop result available |
| res_pop | output | 1 | Result consumed this cycle |
| res_data | input | 16 | Next-hop value |

## Verification
The address push is due in the same cycle as the acceptance of word 6 of a first IP cell. The bench raises its expected-push flag while it processes that very acceptance, and it compares flag and data in that cycle. A stored cell can start at the earliest in the second cycle after its last word is accepted, and later when a result or out_tca holds it. The bench therefore compares output words in order on every cycle that out_valid is high rather than at a fixed delay. Only the start rule is cycle-exact: each out_soc is checked against out_tca one cycle earlier. Lookup latency, address backpressure and transmit-available are varied so that the wait states and the full FIFO are reached.

// File: rtl/relabel_pkg.sv
package relabel_pkg;
    localparam int WORD_W     = 32;
    localparam int CELL_WORDS = 14;
    localparam int IDX_W      = $clog2(CELL_WORDS);
    localparam int VCI_LO     = 4;
    localparam int VCI_W      = 16;
    localparam int ADDR_IDX   = 6;
    localparam int EOF_BIT    = 1;

    typedef struct packed {
        logic              soc;
        logic              ip;
        logic              eop;
        logic [WORD_W-1:0] data;
    } cell_word_t;

    function automatic logic [WORD_W-1:0] put_vci(input logic [WORD_W-1:0] w,
                                                  input logic [VCI_W-1:0] v);
        logic [WORD_W-1:0] r;
        r = w;
        r[VCI_LO +: VCI_W] = v;
        return r;
    endfunction
endpackage

// File: rtl/relabel_cell_fifo.sv
module relabel_cell_fifo
    import relabel_pkg::*;
#(
    parameter int DEPTH_CELLS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  cell_word_t wr_word,
    input  logic       wr_cell_end,
    output logic       full,
    input  logic       rd_en,
    output cell_word_t head,
    input  logic       take_cell,
    output logic       cells_avail
);
    localparam int WORDS = DEPTH_CELLS * CELL_WORDS;
    localparam int PW    = $clog2(WORDS);
    localparam int CW    = $clog2(WORDS + 1);
    localparam int CCW   = $clog2(DEPTH_CELLS + 1);

    cell_word_t      mem [WORDS];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic [CCW-1:0]  cells;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(WORDS - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full        = (count == CW'(WORDS));
    assign head        = mem[rd_ptr];
    assign cells_avail = (cells != '0);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            cells  <= '0;
        end else begin
            if (wr_en) wr_ptr <= step(wr_ptr);
            if (rd_en) rd_ptr <= step(rd_ptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            unique case ({wr_en && wr_cell_end, take_cell})
                2'b10:   cells <= cells + CCW'(1);
                2'b01:   cells <= cells - CCW'(1);
                default: cells <= cells;
            endcase
        end
    end
endmodule

// File: rtl/relabel_in_parser.sv
module relabel_in_parser
    import relabel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VCI_W-1:0]  cfg_vci,
    input  logic              in_valid,
    input  logic              in_soc,
    input  logic [WORD_W-1:0] in_data,
    output logic              in_ready,
    input  logic              fifo_full,
    output logic              wr_en,
    output cell_word_t        wr_word,
    output logic              wr_cell_end,
    output logic              addr_valid,
    input  logic              addr_ready,
    output logic [WORD_W-1:0] addr_data
);
    typedef enum logic {PS_HEADER, PS_PAYLOAD} pstate_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);
    localparam logic [IDX_W-1:0] ADDR_POS = IDX_W'(ADDR_IDX);

    pstate_t          state, state_nx;
    logic [IDX_W-1:0] idx;
    logic             in_pkt;
    logic             cur_first;
    logic             hdr_ip, hdr_last, addr_word, accept;

    assign hdr_ip    = (in_data[VCI_LO +: VCI_W] == cfg_vci);
    assign hdr_last  = in_data[EOF_BIT];
    assign addr_word = (state == PS_PAYLOAD) && (idx == ADDR_POS) && cur_first;
    assign accept    = in_valid && in_ready;

    // outputs
    always_comb begin
        in_ready    = !fifo_full && (!addr_word || addr_ready);
        addr_valid  = in_valid && addr_word && !fifo_full;
        addr_data   = in_data;
        wr_en       = accept && ((state == PS_PAYLOAD) || in_soc);
        wr_cell_end = (state == PS_PAYLOAD) && (idx == LAST_IDX);
        wr_word.soc = (state == PS_HEADER);
        wr_word.ip  = (state == PS_HEADER) && hdr_ip;
        wr_word.eop = hdr_last;
        wr_word.data = in_data;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_HEADER:  if (accept && in_soc) state_nx = PS_PAYLOAD;
            PS_PAYLOAD: if (accept && idx == LAST_IDX) state_nx = PS_HEADER;
            default:    state_nx = PS_HEADER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= PS_HEADER;
            idx       <= '0;
            in_pkt    <= 1'b0;
            cur_first <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == PS_HEADER) begin
                if (accept && in_soc) begin
                    idx       <= IDX_W'(1);
                    cur_first <= hdr_ip && !in_pkt;
                    if (hdr_ip) in_pkt <= !hdr_last;
                end
            end else if (accept) begin
                idx <= idx + IDX_W'(1);
            end
        end
    end
endmodule

// File: rtl/relabel_out_sched.sv
module relabel_out_sched
    import relabel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  cell_word_t        head,
    input  logic              cells_avail,
    output logic              rd_en,
    output logic              take_cell,
    input  logic              out_tca,
    input  logic              res_valid,
    input  logic [VCI_W-1:0]  res_data,
    output logic              res_pop,
    output logic              out_valid,
    output logic              out_soc,
    output logic [WORD_W-1:0] out_data
);
    typedef enum logic [1:0] {OS_IDLE, OS_WAIT_NH, OS_SEND} ostate_t;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_WORDS - 1);

    ostate_t          state, state_nx;
    logic [IDX_W-1:0] widx;
    logic [VCI_W-1:0] nh;
    logic             nh_held, cur_ip, cur_eop, need_nh;

    assign need_nh = head.ip && !nh_held;

    // next state and handshakes
    always_comb begin
        state_nx  = state;
        take_cell = 1'b0;
        res_pop   = 1'b0;
        unique case (state)
            OS_IDLE: begin
                if (cells_avail && out_tca) begin
                    if (!need_nh) begin
                        take_cell = 1'b1;
                        state_nx  = OS_SEND;
                    end else if (res_valid) begin
                        take_cell = 1'b1;
                        res_pop   = 1'b1;
                        state_nx  = OS_SEND;
                    end else begin
                        state_nx  = OS_WAIT_NH;
                    end
                end
            end
            OS_WAIT_NH: begin
                if (res_valid && out_tca) begin
                    take_cell = 1'b1;
                    res_pop   = 1'b1;
                    state_nx  = OS_SEND;
                end
            end
            OS_SEND: if (widx == LAST_IDX) state_nx = OS_IDLE;
            default: state_nx = OS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = (state == OS_SEND);
        rd_en     = out_valid;
        out_soc   = out_valid && head.soc;
        out_data  = (widx == '0 && cur_ip) ? put_vci(head.data, nh) : head.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= OS_IDLE;
            widx    <= '0;
            nh      <= '0;
            nh_held <= 1'b0;
            cur_ip  <= 1'b0;
            cur_eop <= 1'b0;
        end else begin
            state <= state_nx;
            if (take_cell) begin
                widx    <= '0;
                cur_ip  <= head.ip;
                cur_eop <= head.eop;
            end else if (state == OS_SEND) begin
                widx <= widx + IDX_W'(1);
                if (widx == LAST_IDX && cur_ip && cur_eop) nh_held <= 1'b0;
            end
            if (res_pop) begin
                nh      <= res_data;
                nh_held <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/atm_ip_relabel.sv
module atm_ip_relabel
    import relabel_pkg::*;
#(
    parameter int CELL_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cfg_ip_vci,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_soc,
    input  logic [31:0] in_data,
    input  logic        out_tca,
    output logic        out_valid,
    output logic        out_soc,
    output logic [31:0] out_data,
    output logic        addr_valid,
    input  logic        addr_ready,
    output logic [31:0] addr_data,
    input  logic        res_valid,
    output logic        res_pop,
    input  logic [15:0] res_data
);
    cell_word_t wr_word, head;
    logic       wr_en, wr_cell_end, fifo_full, rd_en, take_cell, cells_avail;

    relabel_in_parser u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_vci    (cfg_ip_vci),
        .in_valid   (in_valid),
        .in_soc     (in_soc),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .fifo_full  (fifo_full),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .wr_cell_end(wr_cell_end),
        .addr_valid (addr_valid),
        .addr_ready (addr_ready),
        .addr_data  (addr_data)
    );

    relabel_cell_fifo #(.DEPTH_CELLS(CELL_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_word    (wr_word),
        .wr_cell_end(wr_cell_end),
        .full       (fifo_full),
        .rd_en      (rd_en),
        .head       (head),
        .take_cell  (take_cell),
        .cells_avail(cells_avail)
    );

    relabel_out_sched u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .head       (head),
        .cells_avail(cells_avail),
        .rd_en      (rd_en),
        .take_cell  (take_cell),
        .out_tca    (out_tca),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_pop    (res_pop),
        .out_valid  (out_valid),
        .out_soc    (out_soc),
        .out_data   (out_data)
    );
endmodule

// File: rtl/relabel_checker.sv
module relabel_checker (
    input logic clk,
    input logic rst_n,
    input logic out_tca,
    input logic out_valid,
    input logic out_soc,
    input logic res_valid,
    input logic res_pop
);
    AST_START_AFTER_TCA: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_soc) |-> $past(out_tca));                      // R9
    AST_CELL_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_soc) |-> $past(out_valid));                   // R2
    AST_SOC_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(out_valid)) |-> out_soc);                   // R2
    AST_POP_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        res_pop |-> res_valid);                                          // R8
    AST_POP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_pop |=> !res_pop);                                           // R8
endmodule

bind atm_ip_relabel relabel_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_tca  (out_tca),
    .out_valid(out_valid),
    .out_soc  (out_soc),
    .res_valid(res_valid),
    .res_pop  (res_pop)
);

// File: tb/atm_ip_relabel_tb.sv
`timescale 1ns/1ps
module atm_ip_relabel_tb;
    localparam int CELL_DEPTH = 4;
    localparam int CAP        = CELL_DEPTH * 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_ip_vci = 16'h003E;
    logic        in_valid = 1'b0, in_soc = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_tca = 1'b1;
    logic        addr_ready = 1'b1;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic        in_ready, out_valid, out_soc, addr_valid, res_pop;
    logic [31:0] out_data, addr_data;

    always #2.5 clk = ~clk;

    atm_ip_relabel #(.CELL_DEPTH(CELL_DEPTH)) u_dut (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    int lat = 2;
    bit tca_low = 0, addr_stall = 0, done = 0;
    string cur_tag = "R2";

    // reference state
    logic [32:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] lk_q[$];
    int          lk_t[$];
    logic [31:0] cbuf[14];
    bit m_open = 0, m_ip = 0, m_first = 0, m_inpkt = 0, prev_tca = 1;
    int m_idx = 0, occ = 0, pushes = 0, pops = 0, ip_pkts = 0;
    logic [15:0] m_nh = '0;
    string m_tag = "";

    function automatic logic [15:0] lut(input logic [31:0] a);
        return a[31:16] ^ a[15:0] ^ 16'h1234;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: values at the falling edge are those the next rising edge uses
    always @(negedge clk) begin
        bit exp_push;
        logic [31:0] exp_addr;
        exp_push = 0;
        exp_addr = '0;
        if (rst_n && !done) begin
            cyc++;
            if (occ == CAP) chk(!in_ready, "R10", "in_ready while full", 64'(in_ready), 64'd0);
            if (in_valid && in_ready) begin
                if (!m_open) begin
                    if (in_soc) begin
                        m_open = 1; m_idx = 1; cbuf[0] = in_data; occ++; m_tag = cur_tag;
                        m_ip = (in_data[19:4] == cfg_ip_vci);          // R3 decode
                        m_first = m_ip && !m_inpkt;
                        if (m_first) ip_pkts++;
                        if (m_ip) m_inpkt = !in_data[1];               // R7 end flag
                    end
                end else begin
                    cbuf[m_idx] = in_data; occ++;
                    if (m_idx == 6 && m_first) begin
                        exp_push = 1; exp_addr = in_data; m_nh = lut(in_data);
                    end
                    m_idx++;
                    if (m_idx == 14) begin
                        m_open = 0;
                        for (int k = 0; k < 14; k++) begin
                            logic [31:0] w;
                            w = cbuf[k];
                            if (k == 0 && m_ip) w[19:4] = m_nh;
                            exp_q.push_back({k == 0, w});
                            tag_q.push_back((k == 0 && m_ip) ? "R6" : m_tag);
                        end
                    end
                end
            end
            if (exp_push || (addr_valid && addr_ready)) begin
                chk(exp_push == (addr_valid && addr_ready), "R5", "address push",
                    64'(addr_valid && addr_ready), 64'(exp_push));
                chk(addr_data == exp_addr, "R5", "address value", 64'(addr_data), 64'(exp_addr));
            end
            if (addr_valid && addr_ready) begin
                pushes++;
                lk_q.push_back(lut(addr_data));
                lk_t.push_back(cyc + lat);
            end
            if (res_pop) begin
                chk(res_valid, "R8", "pop without result", 64'(res_valid), 64'd1);
                pops++;
                if (lk_q.size() > 0) begin void'(lk_q.pop_front()); void'(lk_t.pop_front()); end
            end
            if (out_valid) begin
                logic [32:0] e;
                string t;
                occ--;
                if (exp_q.size() == 0) begin
                    chk(0, "R2", "unexpected output word", {31'd0, out_soc, out_data}, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_soc, out_data} == e, t, "output word",
                        {31'd0, out_soc, out_data}, {31'd0, e});
                end
                if (out_soc) chk(prev_tca, "R9", "cell start without prior tca", 64'(prev_tca), 64'd1);
            end
            prev_tca = out_tca;
            if (cyc > 150000) begin
                chk(0, "R2", "watchdog expired", 64'(cyc), 64'd0);
                done = 1;
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    // lookup engine, transmit-available and address backpressure
    always @(posedge clk) begin
        #1;
        res_valid  = (lk_q.size() > 0) && (cyc >= lk_t[0]);
        res_data   = (lk_q.size() > 0) ? lk_q[0] : 16'h0;
        out_tca    = !tca_low;
        addr_ready = !(addr_stall && (cyc % 7 != 0));
    end

    task automatic send_word(input logic [31:0] d, input bit soc);
        in_valid = 1; in_data = d; in_soc = soc;
        forever begin @(negedge clk); if (in_ready) break; end
        @(posedge clk); #1;
        in_valid = 0; in_soc = 0;
    endtask

    task automatic send_cell(input logic [15:0] vci, input bit last, input bit clp,
                             input logic [31:0] dest, input string tag);
        cur_tag = tag;
        send_word({12'hA5C, vci, 1'b0, 1'b0, last, clp}, 1);
        send_word(32'h0000_00C3, 0);
        for (int k = 2; k < 14; k++)
            send_word((k == 6) ? dest : {16'hBEEF, vci[7:0], 8'(k)}, 0);
    endtask

    task automatic drain();
        int n;
        n = 0;
        while ((exp_q.size() != 0 || out_valid) && n < 5000) begin @(posedge clk); n++; end
        repeat (4) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !addr_valid && !res_pop && in_ready, "R1", "reset outputs",
            {60'd0, out_valid, addr_valid, res_pop, in_ready}, 64'h1);
        @(posedge clk); #1; rst_n = 1;
        @(posedge clk); #1;

        send_cell(16'h003E, 1, 0, 32'h0ABA_A000, "R6");         // single-cell IP
        send_cell(16'h0055, 1, 1, 32'h1111_2222, "R4");         // other circuit
        send_word(32'hDEAD_0001, 0);                            // R2 stray word dropped
        send_cell(16'h003E, 0, 1, 32'h0ABA_C000, "R7");         // 3-cell packet
        send_cell(16'h0070, 0, 0, 32'h3333_4444, "R4");         // interleaved other circuit
        send_cell(16'h003E, 0, 0, 32'h5555_6666, "R7");
        send_cell(16'h003E, 1, 0, 32'h7777_8888, "R7");
        drain();

        lat = 40;                                               // R8 wait for result
        send_cell(16'h003E, 0, 0, 32'hDA80_0000, "R8");
        send_cell(16'h003E, 1, 1, 32'h9999_AAAA, "R8");
        drain();
        lat = 3;

        addr_stall = 1;                                         // R5 address backpressure
        send_cell(16'h003E, 1, 0, 32'h8000_0000, "R5");
        send_cell(16'h003E, 1, 0, 32'hC0A8_0101, "R5");
        addr_stall = 0;
        drain();

        tca_low = 1;                                            // R9 and R10
        fork
            begin
                for (int c = 0; c < 7; c++)
                    send_cell((c % 2 == 0) ? 16'h003E : 16'h0042, 1, c[0],
                              32'h0A00_0000 + 32'(c), "R10");
            end
            begin repeat (400) @(posedge clk); #1; tca_low = 0; end
        join
        drain();

        cfg_ip_vci = 16'h0064;                                  // R11 and R3 reclassify
        send_cell(16'h003E, 1, 0, 32'h0ABA_C000, "R11");
        send_cell(16'h0064, 0, 0, 32'h0ABA_A000, "R3");
        send_cell(16'h0064, 1, 0, 32'h0102_0304, "R3");
        drain();

        chk(exp_q.size() == 0, "R2", "words still expected", 64'(exp_q.size()), 64'd0);
        chk(pushes == ip_pkts, "R5", "address pushes per packet", 64'(pushes), 64'(ip_pkts));
        chk(pops == ip_pkts, "R8", "results popped per packet", 64'(pops), 64'(ip_pkts));
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule